// File: doc/BRIEF.md
# Interleaved-Bit Pixel Serializer

This block converts a stream of display bytes into one 3-bit colour per clock cycle. Each byte carries 8, 4 or 2 pixels, depending on the selected colour depth. A pixel's bits are not stored side by side. They are spread across the byte at a fixed stride. The block gathers the bits of each pixel into a 4-bit colour index, maps that index through a fixed palette, and holds each pixel on the output for 1, 2 or 4 cycles so that every mode fills the same line width.

A fetch unit places the next display byte on `byte_in`. The block samples it in the first cycle of the display window. After that, it samples a new byte in the cycle where the last pixel of the current byte has run its full hold time. In every other cycle `byte_in` is ignored. The sampled byte is kept in an internal holding register, so the fetch unit may change `byte_in` freely. Outside the display window, and on blank spacing lines, the output is black.

Control is a two-state machine. In `ST_IDLE` the block waits for the window. START moves it from `ST_IDLE` to `ST_SHOW` when the window opens, and it samples the first byte in that cycle. While in `ST_SHOW` with the window open, the block takes one of three transitions each cycle:
- HOLD keeps the current pixel.
- STEP moves to the next pixel of the held byte.
- RELOAD samples a fresh byte and restarts at pixel 0.

STOP returns the machine to `ST_IDLE` whenever the window closes. Every output is registered, so the colour for input cycle t appears after the clock edge that ends cycle t.

Top module: `planar_pixel_serializer`

## Requirements
- R1: While reset is asserted and right after it is released, `rgb_out` is 0 and the machine is in `ST_IDLE`.
- R2: In the first cycle that `window_on` is high after `ST_IDLE`, `byte_in` is sampled and its pixel 0 appears on `rgb_out` after that clock edge.
- R3: With `depth_sel`=0 (1 bit per pixel) a byte gives eight pixels, and pixel n is bit 7−n.
- R4: With `depth_sel`=1 (2 bits per pixel) a byte gives four pixels, and pixel n has colour index {bit 7−n, bit 3−n}.
- R5: With `depth_sel`=2 or 3 (4 bits per pixel) a byte gives two pixels: pixel 0 is {b7,b5,b3,b1} and pixel 1 is {b6,b4,b2,b0}.
- R6: Each pixel is held for 1, 2 or 4 cycles when `scale_sel` is 0, 1 or 2–3 respectively.
- R7: After the first byte, `byte_in` is sampled only in the cycle that follows the full hold of the last pixel of the held byte; its value in all other cycles has no effect on `rgb_out`.
- R8: The palette maps colour index i to i mod 8 (index bit 3 is ignored). `rgb_out[0]` is red (palette bit 0), `rgb_out[1]` is green (bit 1) and `rgb_out[2]` is blue (bit 2).
- R9: A cycle with `window_on` low yields `rgb_out`=0 after its edge and returns the machine to `ST_IDLE`, so reopening the window restarts at pixel 0 of a newly sampled byte.
- R10: A cycle with `line_blank` high yields `rgb_out`=0 after its edge.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| byte_in | input | 8 | Display byte offered by the fetch unit |
| depth_sel | input | 2 | Colour depth: 0 = 1 bpp, 1 = 2 bpp, 2/3 = 4 bpp |
| scale_sel | input | 2 | Pixel hold: 0 = 1 cycle, 1 = 2 cycles, 2/3 = 4 cycles |
| window_on | input | 1 | High inside the display window |
| line_blank | input | 1 | High on a blank spacing line |
| rgb_out | output | 3 | Registered colour: bit 0 red, bit 1 green, bit 2 blue |

## Verification
The bench changes `byte_in` every cycle. If the design sampled the byte in the wrong cycle, or read it live instead of from the holding register, pixels from unrelated bytes would show up on the output.

It runs every depth with every hold length, including 4 bpp bytes whose bit 7 sets index bit 3. A design that mixed up the interleave or used index bit 3 in the palette would show wrong colours.

It closes the window in the middle of a byte and reopens it. A design that kept its pixel position across the gap would resume at the old pixel instead of pixel 0 of a fresh byte.

It also raises `line_blank` in the middle of a line, to catch any design that lets colour through on a spacing line.

// File: rtl/pser_pkg.sv
package pser_pkg;

    typedef enum logic {
        ST_IDLE,
        ST_SHOW
    } pser_state_t;

    localparam int BYTE_W = 8;
    localparam int IDX_W  = 3;
    localparam int CNT_W  = 3;
    localparam int CI_W   = 4;
    localparam int RGB_W  = 3;

    // Cycles each pixel is held for a scale code.
    function automatic logic [CNT_W-1:0] hold_len(input logic [1:0] code);
        case (code)
            2'd0:    return CNT_W'(1);
            2'd1:    return CNT_W'(2);
            default: return CNT_W'(4);
        endcase
    endfunction

    // Index of the last pixel in a byte for a depth code.
    function automatic logic [IDX_W-1:0] last_pix(input logic [1:0] code);
        case (code)
            2'd0:    return IDX_W'(7);
            2'd1:    return IDX_W'(3);
            default: return IDX_W'(1);
        endcase
    endfunction

endpackage

// File: rtl/pser_extract.sv
module pser_extract
    import pser_pkg::*;
(
    input  logic [BYTE_W-1:0] byte_val,
    input  logic [IDX_W-1:0]  pix_idx,
    input  logic [1:0]        depth_sel,
    output logic [CI_W-1:0]   colour_idx
);
    localparam int N1 = BYTE_W;
    localparam int N2 = BYTE_W / 2;
    localparam int N4 = BYTE_W / 4;

    logic [CI_W-1:0] c1 [N1];
    logic [CI_W-1:0] c2 [N2];
    logic [CI_W-1:0] c4 [N4];

    // One candidate index per pixel slot, per depth.
    for (genvar g = 0; g < N1; g++) begin : g_d1
        assign c1[g] = {3'b000, byte_val[BYTE_W-1-g]};
    end
    for (genvar g = 0; g < N2; g++) begin : g_d2
        assign c2[g] = {2'b00, byte_val[BYTE_W-1-g], byte_val[N2-1-g]};
    end
    for (genvar g = 0; g < N4; g++) begin : g_d4
        assign c4[g] = {byte_val[7-g], byte_val[5-g], byte_val[3-g], byte_val[1-g]};
    end

    always_comb begin
        case (depth_sel)
            2'd0:    colour_idx = c1[pix_idx];
            2'd1:    colour_idx = c2[pix_idx[1:0]];
            default: colour_idx = c4[pix_idx[0]];
        endcase
    end

endmodule

// File: rtl/pser_palette.sv
module pser_palette
    import pser_pkg::*;
(
    input  logic [CI_W-1:0]  colour_idx,
    output logic [RGB_W-1:0] rgb
);
    logic [RGB_W-1:0] entry;

    // Fixed palette: entry i holds i mod 8.
    assign entry = colour_idx[RGB_W-1:0];

    // bit 0 red, bit 1 green, bit 2 blue
    assign rgb = {entry[2], entry[1], entry[0]};

endmodule

// File: rtl/planar_pixel_serializer.sv
module planar_pixel_serializer
    import pser_pkg::*;
(
    input  logic              clk,
    input  logic              rst_n,
    input  logic [7:0]        byte_in,
    input  logic [1:0]        depth_sel,
    input  logic [1:0]        scale_sel,
    input  logic              window_on,
    input  logic              line_blank,
    output logic [2:0]        rgb_out
);
    pser_state_t       state_q, state_d;
    logic [BYTE_W-1:0] hold_byte_q;
    logic [IDX_W-1:0]  idx_q;
    logic [CNT_W-1:0]  cnt_q;

    logic              load, adv, step;
    logic [CNT_W-1:0]  hold;
    logic [IDX_W-1:0]  last;
    logic [BYTE_W-1:0] cur_byte;
    logic [IDX_W-1:0]  cur_idx;
    logic [CI_W-1:0]   colour_idx;
    logic [RGB_W-1:0]  pal_rgb;

    assign hold = hold_len(scale_sel);
    assign last = last_pix(depth_sel);
    assign step = (cnt_q >= hold);

    // Next state and transition decode.
    always_comb begin
        state_d = state_q;
        load    = 1'b0;
        adv     = 1'b0;
        unique case (state_q)
            ST_IDLE: begin
                if (window_on) begin          // START
                    load    = 1'b1;
                    state_d = ST_SHOW;
                end
            end
            ST_SHOW: begin
                if (!window_on) begin         // STOP
                    state_d = ST_IDLE;
                end else if (step) begin
                    if (idx_q >= last) load = 1'b1;   // RELOAD
                    else               adv  = 1'b1;   // STEP
                end                                   // else HOLD
            end
        endcase
    end

    assign cur_byte = load ? byte_in : hold_byte_q;
    assign cur_idx  = load ? '0 : (adv ? IDX_W'(idx_q + 1'b1) : idx_q);

    // State register.
    always_ff @(posedge clk) begin
        if (!rst_n) state_q <= ST_IDLE;
        else        state_q <= state_d;
    end

    // Pixel position and byte holding register.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            hold_byte_q <= '0;
            idx_q       <= '0;
            cnt_q       <= '0;
        end else if (window_on) begin
            hold_byte_q <= cur_byte;
            idx_q       <= cur_idx;
            cnt_q       <= (load || adv) ? CNT_W'(1) : CNT_W'(cnt_q + 1'b1);
        end
    end

    pser_extract u_extract (
        .byte_val   (cur_byte),
        .pix_idx    (cur_idx),
        .depth_sel  (depth_sel),
        .colour_idx (colour_idx)
    );

    pser_palette u_palette (
        .colour_idx (colour_idx),
        .rgb        (pal_rgb)
    );

    // Output register.
    always_ff @(posedge clk) begin
        if (!rst_n)                       rgb_out <= '0;
        else if (window_on && !line_blank) rgb_out <= pal_rgb;
        else                              rgb_out <= '0;
    end

endmodule

// File: rtl/pser_chk.sv
module pser_chk
    import pser_pkg::*;
(
    input logic             clk,
    input logic             rst_n,
    input logic             window_on,
    input logic             line_blank,
    input logic [1:0]       scale_sel,
    input logic [2:0]       rgb_out,
    input pser_state_t      state_q,
    input logic [IDX_W-1:0] idx_q,
    input logic [CNT_W-1:0] cnt_q
);
    // R9
    black_outside_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !window_on |=> rgb_out == 3'd0);

    // R10
    blank_line_chk: assert property (@(posedge clk) disable iff (!rst_n)
        line_blank |=> rgb_out == 3'd0);

    // R9
    idle_return_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !window_on |=> state_q == ST_IDLE);

    // R2
    first_load_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (state_q == ST_IDLE && window_on) |=>
            (state_q == ST_SHOW && idx_q == '0 && cnt_q == CNT_W'(1)));

    // R6
    hold_keep_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (state_q == ST_SHOW && window_on && cnt_q < hold_len(scale_sel)) |=>
            idx_q == $past(idx_q));

    // R6
    count_live_chk: assert property (@(posedge clk) disable iff (!rst_n)
        state_q == ST_SHOW |-> cnt_q != '0);

endmodule

bind planar_pixel_serializer pser_chk u_chk (
    .clk        (clk),
    .rst_n      (rst_n),
    .window_on  (window_on),
    .line_blank (line_blank),
    .scale_sel  (scale_sel),
    .rgb_out    (rgb_out),
    .state_q    (state_q),
    .idx_q      (idx_q),
    .cnt_q      (cnt_q)
);

// File: tb/planar_pixel_serializer_test.sv
`timescale 1ns/1ps
module planar_pixel_serializer_test;

    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic [7:0] byte_in = '0;
    logic [1:0] depth_sel = '0;
    logic [1:0] scale_sel = '0;
    logic       window_on = 1'b0;
    logic       line_blank = 1'b0;
    logic [2:0] rgb_out;

    int checks = 0;
    int errors = 0;

    logic [2:0] exp_q[$];
    string      tag_q[$];

    // reference model state
    bit         m_act = 0;
    logic [7:0] m_byte = '0;
    int         m_idx = 0;
    int         m_cnt = 0;

    always #5 clk = ~clk;

    planar_pixel_serializer uut (
        .clk        (clk),
        .rst_n      (rst_n),
        .byte_in    (byte_in),
        .depth_sel  (depth_sel),
        .scale_sel  (scale_sel),
        .window_on  (window_on),
        .line_blank (line_blank),
        .rgb_out    (rgb_out)
    );

    function automatic int pix_count(input logic [1:0] d);
        return (d == 2'd0) ? 8 : (d == 2'd1) ? 4 : 2;
    endfunction

    function automatic int hold_cycles(input logic [1:0] h);
        return (h == 2'd0) ? 1 : (h == 2'd1) ? 2 : 4;
    endfunction

    // colour index per R3/R4/R5, palette per R8
    function automatic logic [2:0] ref_colour(input logic [7:0] b, input int n,
                                              input logic [1:0] d);
        int ci;
        if (d == 2'd0)      ci = b[7-n];
        else if (d == 2'd1) ci = 2 * b[7-n] + b[3-n];
        else if (n == 0)    ci = 8*b[7] + 4*b[5] + 2*b[3] + b[1];
        else                ci = 8*b[6] + 4*b[4] + 2*b[2] + b[0];
        return 3'(ci % 8);
    endfunction

    task automatic finish_run();
        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    endtask

    // driver: one cycle of stimulus, expected value pushed to the scoreboard
    task automatic drive(input logic [7:0] b, input logic [1:0] d, input logic [1:0] h,
                         input bit w, input bit bl, input string tag);
        logic [2:0] e;
        @(negedge clk);
        byte_in = b; depth_sel = d; scale_sel = h; window_on = w; line_blank = bl;
        if (!w) begin
            m_act = 0;
            e = 3'd0;
        end else begin
            if (!m_act) begin
                m_act = 1; m_byte = b; m_idx = 0; m_cnt = 1;
            end else if (m_cnt >= hold_cycles(h)) begin
                if (m_idx >= pix_count(d) - 1) begin
                    m_byte = b; m_idx = 0;
                end else begin
                    m_idx = m_idx + 1;
                end
                m_cnt = 1;
            end else begin
                m_cnt = m_cnt + 1;
            end
            e = bl ? 3'd0 : ref_colour(m_byte, m_idx, d);
        end
        exp_q.push_back(e);
        tag_q.push_back(tag);
    endtask

    // monitor: compares each result after the edge that produced it
    initial begin
        forever begin
            @(posedge clk);
            #1;
            if (exp_q.size() > 0) begin
                logic [2:0] e;
                string t;
                e = exp_q.pop_front();
                t = tag_q.pop_front();
                checks++;
                if (rgb_out !== e) begin
                    errors++;
                    $display("FAIL %s: rgb_out actual %0d expected %0d", t, rgb_out, e);
                end
            end
        end
    end

    task automatic line(input logic [1:0] d, input logic [1:0] h, input int len,
                        input int seed, input string tag);
        for (int i = 0; i < len; i++)
            drive(8'(i * 37 + seed), d, h, 1'b1, 1'b0, tag);
        for (int i = 0; i < 3; i++)
            drive(8'(i + seed), d, h, 1'b0, 1'b0, "R9");
    endtask

    initial begin
        #1000000;
        errors++;
        $display("FAIL watchdog: run did not complete, actual hung expected done");
        finish_run();
    end

    initial begin
        for (int i = 0; i < 4; i++) @(negedge clk);
        // R1: output black during reset
        checks++;
        if (rgb_out !== 3'd0) begin
            errors++;
            $display("FAIL R1: rgb_out actual %0d expected 0", rgb_out);
        end
        rst_n = 1'b1;
        drive(8'hFF, 2'd0, 2'd0, 1'b0, 1'b0, "R1");

        line(2'd2, 2'd0, 10, 5,   "R2");
        line(2'd0, 2'd0, 40, 11,  "R3");
        line(2'd1, 2'd1, 40, 23,  "R4");
        line(2'd2, 2'd2, 40, 129, "R5 R8");
        line(2'd3, 2'd1, 20, 200, "R5");
        line(2'd0, 2'd2, 70, 7,   "R6");
        line(2'd1, 2'd0, 30, 91,  "R6");
        line(2'd2, 2'd3, 24, 63,  "R6");
        line(2'd0, 2'd1, 50, 3,   "R7");
        line(2'd1, 2'd2, 40, 77,  "R7");
        // R9: window closes mid-byte, then reopens
        line(2'd0, 2'd1, 5, 41,   "R9");
        line(2'd1, 2'd1, 3, 99,   "R9");
        line(2'd0, 2'd0, 12, 17,  "R9");
        // R10: blank line inside an open window
        for (int i = 0; i < 30; i++)
            drive(8'(i * 53 + 9), 2'd1, 2'd1, 1'b1, (i >= 5 && i < 13), "R10");
        drive(8'h00, 2'd0, 2'd0, 1'b0, 1'b0, "R9");
        for (int i = 0; i < 16; i++)
            drive(8'hA5, 2'd2, 2'd0, 1'b1, 1'b1, "R10");
        drive(8'h00, 2'd0, 2'd0, 1'b0, 1'b0, "R9");
        @(negedge clk);
        @(negedge clk);
        finish_run();
    end

endmodule